// File: doc/BRIEF.md
# Line-Tagged Packet Router with Per-Line Setup Records

This block sits behind an endpoint byte stream. It splits the stream into two kinds of packet. Data frames are always 64 bytes long. Their first two bytes name a target I/O line and give how many payload bytes are valid. The block forwards exactly that many payload bytes, each tagged with its line number, and swallows the rest of the frame.

Setup packets are 8 bytes long. Each one writes a record into the register slot of the line it names. The record holds a direction, a serial or parallel mode, and a 32-bit parameter. For a serial line that parameter is a timer length; for a parallel line it is the interrupt line to link.

An upstream agent presents one byte per cycle with a valid strobe. A type select beside the strobe marks whether a packet is a setup packet, and it counts only on the first byte of a packet. Malformed headers raise a sticky error flag.

Top module: `pkt_line_router`

## Requirements
- R1: After reset, `out_valid` and `err_flag` are 0 and every per-line setup field (`cfg_dir`, `cfg_mode`, `cfg_param`) reads 0.
- R2: In a data frame, byte 0 is the line number and byte 1 is the valid byte count. Bytes 2..63 are payload. A forwarded payload byte appears on `out_data`, with `out_valid` high and `out_line` equal to the frame's line number, in the cycle after it is accepted. Order is preserved.
- R3: Only the first *count* payload bytes of a frame are forwarded. The remaining bytes up to byte 63 are consumed without output, and the next accepted byte is parsed as a new packet header.
- R4: A count above 62 is treated as 62 and sets `err_flag`.
- R5: A data frame whose line number is 8 or more forwards nothing and sets `err_flag`. Its 64 bytes are still consumed.
- R6: A setup packet is 8 bytes, in this order:
  - byte 0: identifier, ignored
  - byte 1: pin number, which selects the line slot
  - byte 2: direction; bit 0 is stored in `cfg_dir`
  - byte 3: mode; 0 = serial, 1 = parallel; bit 0 is stored in `cfg_mode`
  - bytes 4..7: 32-bit parameter, little-endian, with byte 4 least significant, stored in `cfg_param[32*pin +: 32]`

  The slot updates in the cycle after byte 7 is accepted. A setup packet produces no `out_valid`.
- R7: A setup packet whose pin number is 8 or more changes no slot and sets `err_flag`.
- R8: `in_is_cfg` is sampled only with the first byte of a packet (1 = setup packet, 0 = data frame). Its value on later bytes has no effect.
- R9: Cycles with `in_valid` low are ignored and do not advance the position within a packet.
- R10: Once set, `err_flag` stays high until reset, regardless of later well-formed packets.
- R11: A data frame with count 0 forwards no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input stream byte |
| in_is_cfg | input | 1 | Packet type on first byte: 1 setup, 0 data |
| out_valid | output | 1 | Forwarded byte strobe |
| out_data | output | 8 | Forwarded payload byte |
| out_line | output | 3 | Line tag of the forwarded byte |
| err_flag | output | 1 | Sticky header error |
| cfg_dir | output | 8 | Direction bit per line |
| cfg_mode | output | 8 | Mode bit per line (0 serial, 1 parallel) |
| cfg_param | output | 256 | 32-bit parameter per line, line n at bits 32n+31..32n |

## Verification
With packets streamed back to back, the last payload byte of a full 62-byte frame leaves the output register in the same cycle that the first byte of the next packet is taken and its type latched. The next packet is a setup packet, so forwarding and type capture share that cycle. The scoreboard must then hold exactly the 62 expected bytes, and the setup slot must show the record afterwards. A second collision is provoked by raising the type select on the count byte and on alternate payload bytes of a data frame: mid-packet type sampling and payload forwarding then coincide, and the frame must still be routed in full.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
   localparam int PARAM_W = 32;

   typedef struct packed {
      logic               dir;
      logic               mode;
      logic [PARAM_W-1:0] param;
   } line_cfg_t;

   localparam int CFG_REC_W = PARAM_W + 2;
endpackage

// File: rtl/rtr_frame_parser.sv
module rtr_frame_parser
   import rtr_pkg::*;
#(
   parameter int DATA_LEN  = 64,
   parameter int CFG_LEN   = 8,
   parameter int NUM_LINES = 8,
   localparam int LINE_W   = $clog2(NUM_LINES),
   localparam int POS_W    = $clog2(DATA_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   input  logic              in_is_cfg,
   output logic              fwd_en,
   output logic [LINE_W-1:0] line_idx,
   output logic              cfg_wr,
   output line_cfg_t         cfg_rec,
   output logic              err_set
);
   localparam int HDR_LEN = 2;
   localparam int MAX_PAY = DATA_LEN - HDR_LEN;
   localparam logic [7:0]       LINE_LIM  = 8'(NUM_LINES);
   localparam logic [7:0]       MAX_PAY_B = 8'(MAX_PAY);
   localparam logic [POS_W-1:0] CFG_LAST  = POS_W'(CFG_LEN - 1);
   localparam logic [POS_W-1:0] DATA_LAST = POS_W'(DATA_LEN - 1);

   if (CFG_LEN != 4 + PARAM_W / 8) begin : g_bad_cfg_len
      $error("setup packet length must hold a 4-byte header and the parameter");
   end
   if (DATA_LEN < 4 || DATA_LEN > 256 || CFG_LEN > DATA_LEN) begin : g_bad_data_len
      $error("data frame length out of range");
   end

   logic [POS_W-1:0]         pos;
   logic                     is_cfg_q;
   logic [7:0]               sel_q;
   logic [POS_W-1:0]         cnt_q;
   logic                     dir_q, mode_q;
   logic [PARAM_W-1:0]       param_q;

   logic                     cur_cfg, last, sel_ok;
   logic [POS_W-1:0]         pidx;

   assign cur_cfg = (pos == '0) ? in_is_cfg : is_cfg_q;
   assign last    = cur_cfg ? (pos == CFG_LAST) : (pos == DATA_LAST);
   assign sel_ok  = sel_q < LINE_LIM;
   assign pidx    = pos - POS_W'(HDR_LEN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos      <= '0;
         is_cfg_q <= 1'b0;
         sel_q    <= '0;
         cnt_q    <= '0;
         dir_q    <= 1'b0;
         mode_q   <= 1'b0;
         param_q  <= '0;
      end else if (in_valid) begin
         pos <= last ? '0 : pos + 1'b1;
         if (pos == '0) is_cfg_q <= in_is_cfg;
         if (cur_cfg) begin
            if (pos == POS_W'(1)) sel_q  <= in_byte;
            if (pos == POS_W'(2)) dir_q  <= in_byte[0];
            if (pos == POS_W'(3)) mode_q <= in_byte[0];
            if (pos >= POS_W'(4)) param_q[8*(pos-POS_W'(4)) +: 8] <= in_byte;
         end else begin
            if (pos == '0) sel_q <= in_byte;
            if (pos == POS_W'(1))
               cnt_q <= (in_byte > MAX_PAY_B) ? POS_W'(MAX_PAY) : in_byte[POS_W-1:0];
         end
      end
   end

   assign fwd_en   = in_valid && !cur_cfg && (pos >= POS_W'(HDR_LEN)) && sel_ok && (pidx < cnt_q);
   assign line_idx = sel_q[LINE_W-1:0];
   assign cfg_wr   = in_valid && cur_cfg && (pos == CFG_LAST) && sel_ok;
   assign cfg_rec  = '{dir: dir_q, mode: mode_q,
                       param: {in_byte, param_q[PARAM_W-9:0]}};
   assign err_set  = in_valid && (
                       (!cur_cfg && pos == '0        && in_byte >= LINE_LIM)  ||
                       (!cur_cfg && pos == POS_W'(1) && in_byte >  MAX_PAY_B) ||
                       ( cur_cfg && pos == POS_W'(1) && in_byte >= LINE_LIM));

   // R9
   pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(pos));
   // R6
   cfg_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cfg_q && pos != '0) |-> (pos <= CFG_LAST));
   // R6
   cfg_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |-> !fwd_en);
endmodule

// File: rtl/rtr_cfg_bank.sv
module rtr_cfg_bank
   import rtr_pkg::*;
#(
   parameter int NUM_LINES = 8,
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [LINE_W-1:0]            wr_idx,
   input  line_cfg_t                    wr_rec,
   output logic [NUM_LINES-1:0]         dir_o,
   output logic [NUM_LINES-1:0]         mode_o,
   output logic [NUM_LINES*PARAM_W-1:0] param_o
);
   line_cfg_t slot_q [NUM_LINES];

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[i] <= '0;
         else if (wr_en && wr_idx == LINE_W'(i))
            slot_q[i] <= wr_rec;
      end
      assign dir_o[i]                     = slot_q[i].dir;
      assign mode_o[i]                    = slot_q[i].mode;
      assign param_o[i*PARAM_W +: PARAM_W] = slot_q[i].param;

      // R7
      slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && wr_idx == LINE_W'(i)) |=> $stable(slot_q[i]));
   end
endmodule

// File: rtl/rtr_out_stage.sv
module rtr_out_stage #(
   parameter int LINE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fwd_en,
   input  logic [7:0]        fwd_byte,
   input  logic [LINE_W-1:0] fwd_line,
   input  logic              err_set,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic [LINE_W-1:0] out_line,
   output logic              err_flag
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_line  <= '0;
         err_flag  <= 1'b0;
      end else begin
         out_valid <= fwd_en;
         if (fwd_en) begin
            out_data <= fwd_byte;
            out_line <= fwd_line;
         end
         if (err_set) err_flag <= 1'b1;
      end
   end

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);
endmodule

// File: rtl/pkt_line_router.sv
module pkt_line_router
   import rtr_pkg::*;
#(
   parameter int DATA_LEN  = 64,
   parameter int CFG_LEN   = 8,
   parameter int NUM_LINES = 8,
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [7:0]                   in_byte,
   input  logic                         in_is_cfg,
   output logic                         out_valid,
   output logic [7:0]                   out_data,
   output logic [LINE_W-1:0]            out_line,
   output logic                         err_flag,
   output logic [NUM_LINES-1:0]         cfg_dir,
   output logic [NUM_LINES-1:0]         cfg_mode,
   output logic [NUM_LINES*PARAM_W-1:0] cfg_param
);
   if (NUM_LINES < 2 || NUM_LINES > 256) begin : g_bad_lines
      $error("line count must be within 2..256");
   end

   logic              fwd_en, cfg_wr, err_set;
   logic [LINE_W-1:0] line_idx;
   line_cfg_t         cfg_rec;

   rtr_frame_parser #(.DATA_LEN(DATA_LEN), .CFG_LEN(CFG_LEN), .NUM_LINES(NUM_LINES)) parser_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_is_cfg(in_is_cfg), .fwd_en(fwd_en), .line_idx(line_idx),
      .cfg_wr(cfg_wr), .cfg_rec(cfg_rec), .err_set(err_set));

   rtr_cfg_bank #(.NUM_LINES(NUM_LINES)) bank_i (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_idx(line_idx),
      .wr_rec(cfg_rec), .dir_o(cfg_dir), .mode_o(cfg_mode), .param_o(cfg_param));

   rtr_out_stage #(.LINE_W(LINE_W)) out_i (
      .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .fwd_byte(in_byte),
      .fwd_line(line_idx), .err_set(err_set), .out_valid(out_valid),
      .out_data(out_data), .out_line(out_line), .err_flag(err_flag));

   // R2
   out_from_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
endmodule

// File: tb/pkt_line_router_tb_top.sv
`timescale 1ns/1ps
module pkt_line_router_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [7:0]   in_byte = '0;
   logic         in_is_cfg = 1'b0;
   logic         out_valid;
   logic [7:0]   out_data;
   logic [2:0]   out_line;
   logic         err_flag;
   logic [7:0]   cfg_dir, cfg_mode;
   logic [255:0] cfg_param;

   int checks = 0;
   int fails  = 0;
   logic [10:0] sb[$];

   always #2 clk = ~clk;

   pkt_line_router dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_is_cfg(in_is_cfg), .out_valid(out_valid), .out_data(out_data),
      .out_line(out_line), .err_flag(err_flag), .cfg_dir(cfg_dir),
      .cfg_mode(cfg_mode), .cfg_param(cfg_param));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b, input logic c);
      @(negedge clk);
      in_valid = 1'b1; in_byte = b; in_is_cfg = c;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0; in_is_cfg = 1'b0;
      end
   endtask

   task automatic send_data(input int line, input int cnt, input int seed,
                            input bit gaps, input bit toggle);
      int n;
      n = (cnt > 62) ? 62 : cnt;
      put(8'(line), 1'b0);
      put(8'(cnt), toggle);
      for (int i = 0; i < 62; i++) begin
         if (gaps && (i % 3 == 0)) idle(1);
         put(8'(seed + i), toggle ? 1'(i) : 1'b0);
         if (line < 8 && i < n) sb.push_back({3'(line), 8'(seed + i)});
      end
   endtask

   task automatic send_cfg(input int pin, input int dir, input int mode, input logic [31:0] prm);
      put(8'h5A, 1'b1);
      put(8'(pin), 1'b0);
      put(8'(dir), 1'b0);
      put(8'(mode), 1'b0);
      for (int i = 0; i < 4; i++) put(prm[8*i +: 8], 1'b0);
   endtask

   task automatic drained(input string req);
      idle(3);
      chk(sb.size() == 0, req, sb.size(), 0);
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   // monitor: pops expected items as the design produces them
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) chk(1'b0, "R3 unexpected output", {out_line, out_data}, 0);
         else begin
            logic [10:0] e;
            e = sb.pop_front();
            chk({out_line, out_data} == e, "R2 routed byte", {out_line, out_data}, e);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      idle(3);
      // R1 reset state
      chk(out_valid == 0, "R1 out_valid", out_valid, 0);
      chk(err_flag == 0, "R1 err_flag", err_flag, 0);
      chk(cfg_param == '0 && cfg_dir == 0 && cfg_mode == 0, "R1 cfg", cfg_param[31:0], 0);
      rst_n = 1'b1;
      idle(1);
      // R2 R3 partial frame, back to back with the next
      send_data(3, 5, 8'h10, 0, 0);
      // full frame followed at once by a setup packet (R6 collision)
      send_data(7, 62, 8'h40, 0, 0);
      send_cfg(2, 1, 1, 32'hA1B2C3D4);
      drained("R3 drain");
      chk(cfg_param[2*32 +: 32] == 32'hA1B2C3D4, "R6 param", cfg_param[2*32 +: 32], 32'hA1B2C3D4);
      chk(cfg_dir[2] && cfg_mode[2], "R6 dir/mode", {cfg_dir[2], cfg_mode[2]}, 2'b11);
      chk(err_flag == 0, "R10 no error yet", err_flag, 0);
      // R11 zero count with R8 type toggling on later bytes
      send_data(0, 0, 8'h77, 0, 1);
      drained("R11 zero count");
      send_data(1, 20, 8'h90, 0, 1);
      drained("R8 toggle ignored");
      // R9 stalls
      send_data(5, 10, 8'hC0, 1, 0);
      drained("R9 gaps");
      send_cfg(6, 0, 0, 32'h00001234);
      idle(2);
      chk(cfg_param[6*32 +: 32] == 32'h1234 && !cfg_mode[6] && !cfg_dir[6], "R6 serial",
          cfg_param[6*32 +: 32], 32'h1234);
      chk(cfg_param[2*32 +: 32] == 32'hA1B2C3D4, "R6 other slot kept", cfg_param[2*32 +: 32], 32'hA1B2C3D4);
      // R5 bad line
      send_data(9, 4, 8'h01, 0, 0);
      drained("R5 dropped");
      chk(err_flag == 1, "R5 err", err_flag, 1);
      send_data(4, 3, 8'h22, 0, 0);
      drained("R5 next frame");
      // reset, then R4 clamp
      idle(1); rst_n = 1'b0; idle(2);
      chk(err_flag == 0 && cfg_param == '0, "R1 reset again", err_flag, 0);
      rst_n = 1'b1; idle(1);
      send_data(1, 100, 8'h05, 0, 0);
      drained("R4 clamp");
      chk(err_flag == 1, "R4 err", err_flag, 1);
      // R7 bad pin
      send_cfg(8, 1, 1, 32'hFFFFFFFF);
      idle(2);
      chk(cfg_param == '0 && cfg_dir == 0 && cfg_mode == 0, "R7 no slot change", cfg_param[31:0], 0);
      send_data(6, 2, 8'h33, 0, 0);
      drained("R10 good frame");
      chk(err_flag == 1, "R10 sticky", err_flag, 1);
      summary();
   end
endmodule